// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 512K eight-bit words that has active-low chip enable, write enable and output enable. The host offers one single-beat read or write at a time through a valid/ready handshake. The block turns each request into a timed sequence of strobes on the memory pins, and for reads it returns the captured byte with a one-cycle valid pulse.

Every phase length is a parameter derived from nanosecond limits and the clock period. Each limit is rounded up to whole cycles. A write holds chip enable and write enable low together for the longer of the pulse-width and data-setup limits, and output enable stays high for the whole write. A read holds chip enable and output enable low for the longer of the address-access and output-enable access limits. After every read, a recovery phase lets the memory release the shared bus before the block may drive it again. The address is registered when a request is accepted. It stays on the pins, unchanged, until the next request is accepted.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, chip enable, write enable and output enable are high, the data-bus drive enable is low and `req_ready` is low. In the second cycle after release, `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The address presented with it appears on `mem_addr` and stays there, whatever `req_addr` does afterwards, for the whole strobe phase.
- R3: A write holds chip enable and write enable low together for exactly WR_LEN cycles, with output enable high throughout. WR_LEN is the largest of ceil(pulse-width/period), ceil(data-setup/period) and ceil(cycle-time/period) minus 2. With the defaults this is 5.
- R4: During every write-enable-low cycle, and in the one cycle after write enable rises, `mem_dq_oe` is high and `mem_dq_out` carries the request's write byte. The memory therefore stores that byte.
- R5: A read holds chip enable and output enable low for exactly RD_LEN cycles, with write enable high. RD_LEN is the largest of ceil(address-access/period), ceil(output-enable-access/period) and ceil(cycle-time/period) minus 2. With the defaults this is 6.
- R6: `rd_data` is sampled from `mem_dq_in` on the edge that ends the last read-strobe cycle. `rd_valid` is high for exactly one cycle, the cycle in which the strobes have just risen. This is RD_LEN+1 cycles after acceptance.
- R7: `mem_dq_oe` is never high while output enable is low. It stays low for at least REL_LEN cycles after output enable rises, where REL_LEN is ceil(bus-release/period), at least 1. With the defaults this is 2.
- R8: Before chip enable falls, the address is on the pins for at least one cycle with all strobes high. The address does not change while chip enable is low.
- R9: `req_ready` is high only while the block is idle, with chip enable high and the bus undriven. From acceptance, `req_ready` returns after WR_LEN+2 cycles for a write and after RD_LEN+1+REL_LEN cycles for a read. This leaves at least one idle cycle between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the read result |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 19 | Address pins of the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the memory data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Byte sampled from the memory data bus |

## Verification
The hardest case to reach from the ports is an early capture of read data, or bus drive that starts while the memory may still be driving. Both look correct whenever the memory returns data at once. The bench memory model therefore returns the inverse of the stored byte until output enable has been low for the full RD_LEN cycles. It also times each drive-enable rise against the last output-enable rise. Random traffic over a small pool of addresses makes read-after-write and write-after-read pairs frequent. Directed requests cover the top and bottom addresses, all-zero and all-one bytes, and reads of never-written words.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and timing helpers for the static RAM sequencer.
// Assumes all timing inputs are non-negative nanosecond counts.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_SETUP,
        ST_WPULSE,
        ST_WEND,
        ST_RACCESS,
        ST_RECOVER
    } seq_state_t;

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        if (ns <= 0) return 0;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one strobe phase.
// Loading N-1 makes 'expired' rise in the N-th cycle after the load edge.
// Assumes load values fit in CNT_W bits.
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length, or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // The phase ends once the count reaches zero.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
// Sequencer for the operation phases: setup, strobe, hold or recovery, idle.
// Assumes the phase timer is loaded on the edge that enters a timed state.
// The read-or-write choice is held in a register from acceptance onward.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int WR_LEN  = 5,
    parameter int RD_LEN  = 6,
    parameter int REL_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output seq_state_t       state_nxt
);
    localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] REL_LOAD = CNT_W'(REL_LEN - 1);

    seq_state_t state_q;
    logic       is_write_q;

    // State register; reset parks in BOOT so ready stays low one extra cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_BOOT;
        else
            state_q <= state_nxt;
    end

    // Remember the operation type of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_write_q <= 1'b0;
        else if (accept)
            is_write_q <= req_write;
    end

    // Next-state and phase-timer control.
    always_comb begin
        state_nxt = state_q;
        accept    = 1'b0;
        capture   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_BOOT: state_nxt = ST_IDLE;
            ST_IDLE: begin
                if (req_valid) begin
                    accept    = 1'b1;
                    state_nxt = ST_SETUP;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (is_write_q) begin
                    tmr_val   = WR_LOAD;
                    state_nxt = ST_WPULSE;
                end else begin
                    tmr_val   = RD_LOAD;
                    state_nxt = ST_RACCESS;
                end
            end
            ST_WPULSE: begin
                if (tmr_expired) state_nxt = ST_WEND;
            end
            ST_WEND: state_nxt = ST_IDLE;
            ST_RACCESS: begin
                if (tmr_expired) begin
                    capture   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = REL_LOAD;
                    state_nxt = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (tmr_expired) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_BOOT;
        endcase
    end

    // The host may present a request only in the idle state.
    always_comb req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_pin_drive.sv
// Registered memory-side pins and host read-return registers.
// The strobes and drive enable are decoded from the next state and then
// registered, so they change only on clock edges and do not glitch.
// Assumes 'accept' and 'capture' come from the sequencer in the same cycle.
module sram_pin_drive
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_nxt,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic strobe_sel;
    logic write_sel;
    logic read_sel;
    logic drive_sel;

    // Decode the pin levels for the state about to be entered.
    always_comb begin
        write_sel  = (state_nxt == ST_WPULSE);
        read_sel   = (state_nxt == ST_RACCESS);
        strobe_sel = write_sel || read_sel;
        drive_sel  = write_sel || (state_nxt == ST_WEND);
    end

    // Strobes and bus drive: all inactive under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= !strobe_sel;
            mem_we_n  <= !write_sel;
            mem_oe_n  <= !read_sel;
            mem_dq_oe <= drive_sel;
        end
    end

    // Address and write byte are registered once, at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Sample the bus at the end of the access window and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq_in;
        end
    end

endmodule

// File: rtl/sram_seq_ctrl.sv
// Top level of the static RAM sequencer.
// Converts valid/ready single-beat requests into timed strobe sequences.
// Phase lengths come from nanosecond limits rounded up to CLK_NS periods.
// Assumes one request at a time and a memory whose outputs are released
// within T_BUS_REL_NS after output enable rises.
module sram_seq_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int DATA_W       = 8,
    parameter int CLK_NS       = 10,
    parameter int T_CYC_NS     = 55,
    parameter int T_WP_NS      = 50,
    parameter int T_DS_NS      = 30,
    parameter int T_AA_NS      = 55,
    parameter int T_OE_NS      = 30,
    parameter int T_BUS_REL_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Setup and end-of-write cycles are fixed at one each, so the strobe
    // phase only has to cover the cycle time minus those two.
    localparam int CYC_BODY = ns_to_cyc(T_CYC_NS, CLK_NS) - 2;
    localparam int WR_LEN   = max_int(1, max_int(ns_to_cyc(T_WP_NS, CLK_NS),
                                      max_int(ns_to_cyc(T_DS_NS, CLK_NS), CYC_BODY)));
    localparam int RD_LEN   = max_int(1, max_int(ns_to_cyc(T_AA_NS, CLK_NS),
                                      max_int(ns_to_cyc(T_OE_NS, CLK_NS), CYC_BODY)));
    localparam int REL_LEN  = max_int(1, ns_to_cyc(T_BUS_REL_NS, CLK_NS));
    localparam int LEN_MAX  = max_int(WR_LEN, max_int(RD_LEN, REL_LEN));
    localparam int CNT_W    = max_int(1, $clog2(LEN_MAX + 1));

    seq_state_t       state_nxt;
    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .WR_LEN (WR_LEN),
        .RD_LEN (RD_LEN),
        .REL_LEN(REL_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .tmr_expired(tmr_expired),
        .req_ready  (req_ready),
        .accept     (accept),
        .capture    (capture),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .state_nxt  (state_nxt)
    );

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    sram_pin_drive #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_in (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_out(mem_dq_out),
        .mem_dq_oe (mem_dq_oe),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
// Protocol checker for the static RAM sequencer, attached by bind.
// Observes only top-level ports.
module sram_seq_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready)); // R1

    AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R3

    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R3

    AST_NO_DRIVE_WHILE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R7

    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |=> !mem_dq_oe); // R7

    AST_ADDR_BEFORE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $stable(mem_addr)); // R8

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R8

    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6

    AST_RDV_AT_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $rose(mem_oe_n)); // R6

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_dq_oe)); // R9

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_seq_ctrl_tb.sv
// Self-checking bench: behavioural memory model, directed corners and
// seeded random traffic. Expected cycle counts are worked out from the
// nanosecond limits at a 10 ns period.
module sram_seq_ctrl_tb;
    localparam int CLK_NS  = 10;
    localparam int WR_LEN  = 5;   // ceil(50/10)
    localparam int RD_LEN  = 6;   // ceil(55/10)
    localparam int REL_LEN = 2;   // ceil(20/10)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0] model [logic [18:0]];
    logic [7:0] refm  [logic [18:0]];
    logic [18:0] cur_addr;
    logic [7:0]  cur_wdata;

    always #(CLK_NS/2) clk = ~clk;

    sram_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mget(input logic [18:0] a);
        return model.exists(a) ? model[a] : 8'h00;
    endfunction

    function automatic logic [7:0] rget(input logic [18:0] a);
        return refm.exists(a) ? refm[a] : 8'h00;
    endfunction

    // Memory model: bus data is valid only after the full access window.
    int rd_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n || mem_ce_n || mem_oe_n || !mem_we_n) rd_cnt = 0;
        else rd_cnt = rd_cnt + 1;
        mem_dq_in = (rd_cnt >= RD_LEN) ? mget(mem_addr) : ~mget(mem_addr);
    end

    // Pin monitor: pulse lengths, hold, turnaround and address stability.
    int          we_run = 0, oe_run = 0, oe_age = 100;
    bit          wr_bad = 1'b0, rd_bad = 1'b0;
    logic [7:0]  last_dq;
    logic        prev_ce_n = 1'b1, prev_oe_q = 1'b0, prev_rdv = 1'b0, prev_dq_oe = 1'b0;
    logic [18:0] prev_addr = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready, "R1",
                "pins during reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11100);
            we_run = 0; oe_run = 0; oe_age = 100;
        end else begin
            if (!mem_we_n) begin
                we_run++;
                if (mem_ce_n || !mem_oe_n || !mem_dq_oe || mem_dq_out !== cur_wdata) wr_bad = 1'b1;
                last_dq = mem_dq_out;
            end else if (we_run != 0) begin
                chk(we_run == WR_LEN, "R3", "write pulse length", we_run, WR_LEN);
                chk(!wr_bad, "R4", "ce/oe/data during write pulse", wr_bad, 0);
                chk(mem_dq_oe && mem_dq_out == cur_wdata, "R4", "data hold after we rise",
                    {mem_dq_oe, mem_dq_out}, {1'b1, cur_wdata});
                model[mem_addr] = last_dq;
                we_run = 0; wr_bad = 1'b0;
            end
            if (!mem_oe_n) begin
                oe_run++;
                if (mem_ce_n || !mem_we_n) rd_bad = 1'b1;
            end else if (oe_run != 0) begin
                chk(oe_run == RD_LEN, "R5", "read strobe length", oe_run, RD_LEN);
                chk(!rd_bad, "R5", "ce low, we high during read", rd_bad, 0);
                chk(rd_valid, "R6", "rd_valid with strobe rise", rd_valid, 1);
                oe_run = 0; rd_bad = 1'b0; oe_age = 0;
            end else if (oe_age < 100) oe_age++;
            if (mem_dq_oe && !prev_dq_oe)
                chk(mem_oe_n && oe_age >= REL_LEN, "R7", "bus drive after oe release",
                    oe_age, REL_LEN);
            if (!mem_ce_n && prev_ce_n) begin
                chk(mem_addr == prev_addr, "R8", "address set up before ce", mem_addr, prev_addr);
                chk(mem_addr == cur_addr, "R2", "address of accepted request", mem_addr, cur_addr);
            end
            if (!mem_ce_n && !prev_ce_n && mem_addr != prev_addr)
                chk(1'b0, "R8", "address moved while ce low", mem_addr, prev_addr);
            if (rd_valid && prev_rdv)
                chk(1'b0, "R6", "rd_valid longer than one cycle", 2, 1);
        end
        prev_ce_n = mem_ce_n; prev_addr = mem_addr; prev_rdv = rd_valid;
        prev_dq_oe = mem_dq_oe; prev_oe_q = mem_oe_n;
    end

    // One request; called and returning at a falling edge.
    task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d);
        int lat;
        int guard;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        guard = 0;
        while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
        cur_addr = a; cur_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 19'($urandom); req_wdata = 8'($urandom);
        chk(!req_ready, "R9", "ready low after accept", req_ready, 0);
        lat = 0;
        if (wr) begin
            while (!req_ready && lat < 50) begin @(negedge clk); lat++; end
            chk(lat == WR_LEN + 2, "R9", "write turnaround", lat, WR_LEN + 2);
            refm[a] = d;
            chk(mget(a) == d, "R4", "byte stored by write", mget(a), d);
        end else begin
            while (!rd_valid && lat < 50) begin @(negedge clk); lat++; end
            chk(lat == RD_LEN + 1, "R6", "read latency", lat, RD_LEN + 1);
            chk(rd_data == rget(a), "R6", "read data", rd_data, rget(a));
            while (!req_ready && lat < 80) begin @(negedge clk); lat++; end
            chk(lat == RD_LEN + 1 + REL_LEN, "R9", "read turnaround", lat, RD_LEN + 1 + REL_LEN);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(!req_ready, "R1", "ready low first cycle after reset", req_ready, 0);
        @(negedge clk);
        chk(req_ready, "R1", "ready high after boot", req_ready, 1);
        // Directed corners
        do_op(1'b0, 19'h30000, 8'h00);       // never written: expects 0
        do_op(1'b1, 19'h7FFFF, 8'hFF);
        do_op(1'b0, 19'h7FFFF, 8'h00);
        do_op(1'b1, 19'h00000, 8'h00);
        do_op(1'b0, 19'h00000, 8'h00);
        do_op(1'b1, 19'h00000, 8'hA5);       // overwrite then read back
        do_op(1'b0, 19'h00000, 8'h00);
        do_op(1'b0, 19'h7FFFF, 8'h00);       // read followed by write: turnaround
        do_op(1'b1, 19'h7FFFF, 8'h3C);
        do_op(1'b0, 19'h7FFFF, 8'h00);
        // Random traffic over a small pool plus wide addresses
        for (int i = 0; i < 200; i++) begin
            logic [18:0] a;
            if (($urandom % 4) != 0) a = 19'(($urandom % 8) * 32'h9E37);
            else a = 19'($urandom);
            do_op(1'($urandom % 2), a, 8'($urandom));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule